// File: doc/BRIEF.md
# DMA Channel Address Sequencer

This block is the engine of one DMA channel. It moves words from a source address space to a destination address space through a simple bus-master port. The port has a read side and a write side, each with a valid/ready handshake and an error input sampled with each beat. Software-facing registers live outside the block. Their values reach it as plain inputs: a direction mode, one address-control code per side, the programmed start addresses, the byte count, and the enable, trigger and soft-reset strobes.

Each beat reads one word at the working source address and holds it in an internal buffer. It then writes that word to the working destination address. After each accepted write, the working addresses advance and the working count drops by the beat size. A side in wrap mode starts over from its programmed address whenever the count runs out. The count then reloads and the channel keeps going without a new trigger. Clearing the enable stops the channel cleanly. A bus error freezes the channel until a soft reset is issued.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset the channel is idle. `busy_o`, `rd_valid_o`, `wr_valid_o`, `err_o` and `srst_busy_o` are 0, and the working count is 0.
- R2: A trigger pulse that is accepted in the idle state loads the working source address, destination address and count from `src_base_i`, `dst_base_i` and `count_i`. On the next cycle `busy_o` is 1 and a read is requested at the source start address.
- R3: A trigger is ignored when any of these holds: `en_i` is 0; the mode is 11; either address control is 01; the count is 0 or not a multiple of 4; or either start address has bits [1:0] not equal to 00.
- R4: Each beat is a read handshake followed by a write handshake. The write carries the word captured on the read. Read and write requests are never raised together. A request holds its valid and address until ready.
- R5: The address control on each side works as follows. 00 adds 4 to the working address after each accepted write. 10 holds the address fixed. The count drops by 4 after each accepted write.
- R6: The peripheral side uses a fixed address whatever its control code says. Mode 01 (peripheral to memory) makes the source the peripheral side. Mode 10 (memory to peripheral) makes the destination the peripheral side. Mode 00 (memory to memory) has no peripheral side.
- R7: When neither effective side control is wrap, the write that brings the count to 0 ends the transfer. `busy_o` is 0 from the next cycle on.
- R8: When either effective side control is 11 (wrap), the write that empties the count reloads the count. That write also sets each wrap side's address back to its start, and the next read follows at once.
- R9: With `en_i` at 0, a read that is already requested still completes its handshake. The captured word is then dropped and no write is issued. A pending write is withdrawn, and the channel goes idle.
- R10: A read or write handshake with its error input high stops the channel and sets `err_o`. No further request is made, and triggers are ignored until a soft reset.
- R11: A soft-reset pulse from any state clears `err_o`, the working count and the working addresses. It then holds `srst_busy_o` high for exactly SRST_CYCLES (default 3) cycles, and triggers are ignored while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Channel enable |
| trig_i | input | 1 | Start pulse |
| srst_i | input | 1 | Soft-reset pulse |
| mode_i | input | 2 | Direction: 00 mem-mem, 01 periph-mem, 10 mem-periph |
| src_ctl_i | input | 2 | Source address control: 00 inc, 10 fixed, 11 wrap |
| dst_ctl_i | input | 2 | Destination address control, same coding |
| src_base_i | input | AW | Programmed source start address |
| dst_base_i | input | AW | Programmed destination start address |
| count_i | input | CW | Programmed byte count |
| rd_valid_o | output | 1 | Read request |
| rd_ready_i | input | 1 | Read accepted, data and error valid |
| rd_addr_o | output | AW | Read address |
| rd_data_i | input | DW | Read data |
| rd_err_i | input | 1 | Read bus error |
| wr_valid_o | output | 1 | Write request |
| wr_ready_i | input | 1 | Write accepted, error valid |
| wr_addr_o | output | AW | Write address |
| wr_data_o | output | DW | Write data |
| wr_err_i | input | 1 | Write bus error |
| busy_o | output | 1 | Transfer active (trigger readback) |
| err_o | output | 1 | Halted on bus error |
| srst_busy_o | output | 1 | Soft reset in progress |
| cur_src_o | output | AW | Working source address |
| cur_dst_o | output | AW | Working destination address |
| cur_cnt_o | output | CW | Working byte count |

## Verification
The hardest case to reach is a disable that lands at a chosen point inside a wrapping transfer. That point may be a read stalled without ready, or a write already requested. A second hard case is an error that strikes on the beat the bench picks. The bench reaches both by stalling the ready inputs and dropping `en_i` on a chosen cycle. It also arms an error flag that fires on the next read handshake. Random ready timing, across all modes and address controls, covers the ordinary beats.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  typedef enum logic [1:0] {
    MODE_M2M = 2'b00,
    MODE_P2M = 2'b01,
    MODE_M2P = 2'b10,
    MODE_RSV = 2'b11
  } xfer_mode_e;

  typedef enum logic [1:0] {
    ADR_INC  = 2'b00,
    ADR_RSV  = 2'b01,
    ADR_FIX  = 2'b10,
    ADR_WRAP = 2'b11
  } adr_ctl_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_WR,
    ST_HALT,
    ST_SRST
  } seq_state_e;
endpackage

// File: rtl/dma_addr_unit.sv
module dma_addr_unit
  import dma_seq_pkg::*;
#(
  parameter int AW   = 32,
  parameter int STEP = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          load_i,
  input  logic          adv_i,
  input  logic          pass_end_i,
  input  logic [1:0]    ctl_i,
  input  logic [AW-1:0] base_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_q <= '0;
    else if (clr_i)  addr_q <= '0;
    else if (load_i) addr_q <= base_i;
    else if (adv_i) begin
      if (ctl_i == ADR_INC)       addr_q <= addr_q + AW'(STEP);
      else if (ctl_i == ADR_WRAP) addr_q <= pass_end_i ? base_i : addr_q + AW'(STEP);
    end
  end

  assign addr_o = addr_q;

  AST_FIX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && !load_i && !clr_i && ctl_i == ADR_FIX |=> $stable(addr_o)); // R5
endmodule

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm
  import dma_seq_pkg::*;
#(
  parameter int CW          = 16,
  parameter int STEP        = 4,
  parameter int SRST_CYCLES = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          trig_i,
  input  logic          srst_i,
  input  logic          start_ok_i,
  input  logic          wrap_i,
  input  logic          rd_hs_i,
  input  logic          rd_err_i,
  input  logic          wr_hs_i,
  input  logic          wr_err_i,
  input  logic [CW-1:0] cnt_base_i,
  output seq_state_e    state_o,
  output logic [CW-1:0] cnt_o,
  output logic          load_o,
  output logic          adv_o,
  output logic          pass_end_o,
  output logic          clr_o,
  output logic          err_o,
  output logic          srst_busy_o
);
  localparam int TW = $clog2(SRST_CYCLES + 1);

  seq_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q;
  logic [TW-1:0] tmr_q;
  logic          last;

  assign last       = cnt_q == CW'(STEP);
  assign clr_o      = srst_i;
  assign load_o     = state_q == ST_IDLE && trig_i && en_i && start_ok_i && !srst_i;
  assign adv_o      = state_q == ST_WR && en_i && wr_hs_i && !wr_err_i && !srst_i;
  assign pass_end_o = adv_o && last;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (load_o) state_d = ST_RD;
      ST_RD: if (rd_hs_i) begin
        if (rd_err_i)   state_d = ST_HALT;
        else if (!en_i) state_d = ST_IDLE; // word dropped
        else            state_d = ST_WR;
      end
      ST_WR: begin
        if (!en_i) state_d = ST_IDLE;
        else if (wr_hs_i) begin
          if (wr_err_i)        state_d = ST_HALT;
          else if (last)       state_d = wrap_i ? ST_RD : ST_IDLE;
          else                 state_d = ST_RD;
        end
      end
      ST_HALT: state_d = ST_HALT;
      ST_SRST: if (tmr_q == '0) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
    if (srst_i) state_d = ST_SRST;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      tmr_q   <= '0;
    end else begin
      state_q <= state_d;
      if (srst_i)              tmr_q <= TW'(SRST_CYCLES - 1);
      else if (tmr_q != '0)    tmr_q <= tmr_q - 1'b1;
      if (clr_o)               cnt_q <= '0;
      else if (load_o)         cnt_q <= cnt_base_i;
      else if (adv_o)          cnt_q <= (last && wrap_i) ? cnt_base_i : cnt_q - CW'(STEP);
    end
  end

  assign state_o     = state_q;
  assign cnt_o       = cnt_q;
  assign err_o       = state_q == ST_HALT;
  assign srst_busy_o = state_q == ST_SRST;

  AST_CNT_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RD || state_q == ST_WR) |-> cnt_q != '0); // R7
  AST_HALT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_HALT && !srst_i |=> state_q == ST_HALT); // R10
  AST_OFF_NO_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_IDLE && !en_i |=> (state_q == ST_IDLE || state_q == ST_SRST)); // R3
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_seq_pkg::*;
#(
  parameter int AW          = 32,
  parameter int CW          = 16,
  parameter int DW          = 32,
  parameter int BEAT_BYTES  = 4,
  parameter int SRST_CYCLES = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          trig_i,
  input  logic          srst_i,
  input  logic [1:0]    mode_i,
  input  logic [1:0]    src_ctl_i,
  input  logic [1:0]    dst_ctl_i,
  input  logic [AW-1:0] src_base_i,
  input  logic [AW-1:0] dst_base_i,
  input  logic [CW-1:0] count_i,
  output logic          rd_valid_o,
  input  logic          rd_ready_i,
  output logic [AW-1:0] rd_addr_o,
  input  logic [DW-1:0] rd_data_i,
  input  logic          rd_err_i,
  output logic          wr_valid_o,
  input  logic          wr_ready_i,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o,
  input  logic          wr_err_i,
  output logic          busy_o,
  output logic          err_o,
  output logic          srst_busy_o,
  output logic [AW-1:0] cur_src_o,
  output logic [AW-1:0] cur_dst_o,
  output logic [CW-1:0] cur_cnt_o
);
  localparam int AL = $clog2(BEAT_BYTES);

  seq_state_e state;
  logic [1:0] cfg_mode, cfg_sctl, cfg_dctl;
  logic [1:0][1:0]    eff_ctl;
  logic [1:0][AW-1:0] base_a, addr_a;
  logic [DW-1:0] buf_q;
  logic start_ok, wrap, rd_hs, wr_hs, load, adv, pass_end, clr;

  assign start_ok = mode_i != MODE_RSV && src_ctl_i != ADR_RSV && dst_ctl_i != ADR_RSV
                 && count_i != '0 && count_i[AL-1:0] == '0
                 && src_base_i[AL-1:0] == '0 && dst_base_i[AL-1:0] == '0;

  // peripheral side never moves
  assign eff_ctl[0] = (cfg_mode == MODE_P2M) ? ADR_FIX : cfg_sctl;
  assign eff_ctl[1] = (cfg_mode == MODE_M2P) ? ADR_FIX : cfg_dctl;
  assign wrap       = eff_ctl[0] == ADR_WRAP || eff_ctl[1] == ADR_WRAP;
  assign base_a[0]  = src_base_i;
  assign base_a[1]  = dst_base_i;

  assign rd_hs = rd_valid_o && rd_ready_i;
  assign wr_hs = wr_valid_o && wr_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_mode <= '0;
      cfg_sctl <= '0;
      cfg_dctl <= '0;
      buf_q    <= '0;
    end else begin
      if (load) begin
        cfg_mode <= mode_i;
        cfg_sctl <= src_ctl_i;
        cfg_dctl <= dst_ctl_i;
      end
      if (clr)                        buf_q <= '0;
      else if (rd_hs && !rd_err_i)    buf_q <= rd_data_i;
    end
  end

  dma_seq_fsm #(.CW(CW), .STEP(BEAT_BYTES), .SRST_CYCLES(SRST_CYCLES)) u_fsm (
    .clk_i, .rst_ni, .en_i, .trig_i, .srst_i,
    .start_ok_i (start_ok),
    .wrap_i     (wrap),
    .rd_hs_i    (rd_hs),
    .rd_err_i,
    .wr_hs_i    (wr_hs),
    .wr_err_i,
    .cnt_base_i (count_i),
    .state_o    (state),
    .cnt_o      (cur_cnt_o),
    .load_o     (load),
    .adv_o      (adv),
    .pass_end_o (pass_end),
    .clr_o      (clr),
    .err_o,
    .srst_busy_o
  );

  for (genvar s = 0; s < 2; s++) begin : g_side
    dma_addr_unit #(.AW(AW), .STEP(BEAT_BYTES)) u_addr (
      .clk_i, .rst_ni,
      .clr_i      (clr),
      .load_i     (load),
      .adv_i      (adv),
      .pass_end_i (pass_end),
      .ctl_i      (eff_ctl[s]),
      .base_i     (base_a[s]),
      .addr_o     (addr_a[s])
    );
  end

  assign cur_src_o  = addr_a[0];
  assign cur_dst_o  = addr_a[1];
  assign rd_valid_o = state == ST_RD;
  assign wr_valid_o = state == ST_WR;
  assign rd_addr_o  = addr_a[0];
  assign wr_addr_o  = addr_a[1];
  assign wr_data_o  = buf_q;
  assign busy_o     = rd_valid_o || wr_valid_o;

  AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o && !rd_ready_i && !srst_i |=> rd_valid_o && $stable(rd_addr_o)); // R4
  AST_ONE_SIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_valid_o && wr_valid_o)); // R4
  AST_WR_AFTER_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_valid_o) |-> $past(rd_hs)); // R4
  AST_PERIPH_FIX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && cfg_mode == MODE_P2M && !srst_i |=> !busy_o || $stable(cur_src_o)); // R6
  AST_ERR_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_hs && rd_err_i && !srst_i |=> err_o && !busy_o); // R10
endmodule

// File: tb/sim_dma_chan_seq.sv
`timescale 1ns/1ps
module sim_dma_chan_seq;
  logic        clk_i = 0, rst_ni = 0;
  logic        en_i = 0, trig_i = 0, srst_i = 0;
  logic [1:0]  mode_i = 0, src_ctl_i = 0, dst_ctl_i = 0;
  logic [31:0] src_base_i = 0, dst_base_i = 0;
  logic [15:0] count_i = 0;
  logic        rd_valid_o, rd_ready_i = 0, rd_err_i = 0;
  logic [31:0] rd_addr_o, rd_data_i = 0;
  logic        wr_valid_o, wr_ready_i = 0, wr_err_i = 0;
  logic [31:0] wr_addr_o, wr_data_o;
  logic        busy_o, err_o, srst_busy_o;
  logic [31:0] cur_src_o, cur_dst_o;
  logic [15:0] cur_cnt_o;

  always #10 clk_i = ~clk_i;

  dma_chan_seq u0 (.*);

  int n_chk = 0, n_bad = 0, cyc = 0;
  int nrd = 0, nwr = 0;
  bit hold_rd = 0, inject_rd_err = 0, exp_idle = 0, cnt_chk = 0;
  logic [31:0] m_src, m_dst, m_sb, m_db, m_data;
  logic [15:0] m_cnt, m_bc;
  logic [1:0]  m_sc, m_dc;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] memf(input logic [31:0] a);
    return {a[15:0] ^ 16'h5a3c, ~a[15:0]};
  endfunction

  function automatic logic [1:0] eff(input logic [1:0] mode, input bit dst, input logic [1:0] c);
    if (!dst && mode == 2'b01) return 2'b10;
    if (dst && mode == 2'b10) return 2'b10;
    return c;
  endfunction

  function automatic logic [31:0] nxt(input logic [1:0] c, input logic [31:0] a, input logic [31:0] b, input bit pe);
    if (c == 2'b00) return a + 4;
    if (c == 2'b11) return pe ? b : a + 4;
    return a;
  endfunction

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  task automatic tick();
    @(negedge clk_i);
    if (exp_idle) begin chk(busy_o == 0, "R7 busy after last write", busy_o, 0); exp_idle = 0; end
    if (cnt_chk) begin chk(cur_cnt_o == m_cnt, "R5/R8 working count", cur_cnt_o, m_cnt); cnt_chk = 0; end
    chk(!(rd_valid_o && wr_valid_o), "R4 one side at a time", {rd_valid_o, wr_valid_o}, 0);
    rd_ready_i = !hold_rd && ($urandom % 4 != 0);
    wr_ready_i = ($urandom % 4 != 0);
    rd_err_i = 0; wr_err_i = 0;
    if (rd_valid_o && rd_ready_i) begin
      chk(rd_addr_o == m_src, "R4/R5/R6 read address", rd_addr_o, m_src);
      m_data = memf(rd_addr_o);
      rd_data_i = m_data;
      if (inject_rd_err) begin rd_err_i = 1; inject_rd_err = 0; end
      nrd++;
    end
    if (wr_valid_o && wr_ready_i) begin
      bit pe;
      chk(wr_addr_o == m_dst, "R5/R6/R8 write address", wr_addr_o, m_dst);
      chk(wr_data_o == m_data, "R4 write data", wr_data_o, m_data);
      nwr++;
      m_cnt = m_cnt - 4;
      pe = (m_cnt == 0);
      m_src = nxt(m_sc, m_src, m_sb, pe);
      m_dst = nxt(m_dc, m_dst, m_db, pe);
      if (pe && (m_sc == 2'b11 || m_dc == 2'b11)) m_cnt = m_bc;
      else if (pe) exp_idle = 1;
      cnt_chk = 1;
    end
  endtask

  task automatic start(input logic [1:0] md, input logic [1:0] sc, input logic [1:0] dc,
                       input logic [31:0] sb, input logic [31:0] db, input logic [15:0] bc, input bit ok);
    @(negedge clk_i);
    rd_ready_i = 0; wr_ready_i = 0;
    mode_i = md; src_ctl_i = sc; dst_ctl_i = dc;
    src_base_i = sb; dst_base_i = db; count_i = bc; trig_i = 1;
    @(negedge clk_i);
    trig_i = 0;
    chk(busy_o == ok, ok ? "R2 trigger accepted" : "R3 trigger ignored", busy_o, ok);
    if (ok) begin
      chk(cur_src_o == sb && rd_valid_o && rd_addr_o == sb, "R2 source loaded", cur_src_o, sb);
      chk(cur_dst_o == db, "R2 destination loaded", cur_dst_o, db);
      chk(cur_cnt_o == bc, "R2 count loaded", cur_cnt_o, bc);
      m_src = sb; m_dst = db; m_sb = sb; m_db = db; m_cnt = bc; m_bc = bc;
      m_sc = eff(md, 0, sc); m_dc = eff(md, 1, dc);
    end else begin
      chk(rd_valid_o == 0, "R3 no read request", rd_valid_o, 0);
    end
  endtask

  task automatic run_idle();
    int n = 0;
    do begin tick(); n++; end while ((busy_o || exp_idle) && n < 2000);
  endtask

  initial begin
    int n0, w0, len;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    chk(!busy_o && !rd_valid_o && !wr_valid_o && !err_o && !srst_busy_o && cur_cnt_o == 0,
        "R1 reset state", {busy_o, rd_valid_o, wr_valid_o, err_o, srst_busy_o}, 0);

    // R3: rejected triggers
    en_i = 0;
    start(2'b00, 2'b00, 2'b00, 32'h100, 32'h200, 16'd8, 0);
    en_i = 1;
    start(2'b11, 2'b00, 2'b00, 32'h100, 32'h200, 16'd8, 0);
    start(2'b00, 2'b01, 2'b00, 32'h100, 32'h200, 16'd8, 0);
    start(2'b00, 2'b00, 2'b01, 32'h100, 32'h200, 16'd8, 0);
    start(2'b00, 2'b00, 2'b00, 32'h100, 32'h200, 16'd0, 0);
    start(2'b00, 2'b00, 2'b00, 32'h100, 32'h200, 16'd6, 0);
    start(2'b00, 2'b00, 2'b00, 32'h102, 32'h200, 16'd8, 0);
    start(2'b00, 2'b00, 2'b00, 32'h100, 32'h201, 16'd8, 0);

    // R4 R5 R6 R7: random non-wrap transfers over all modes
    for (int i = 0; i < 40; i++) begin
      logic [1:0] md, sc, dc;
      md = 2'($urandom % 3);
      sc = ($urandom % 2) ? 2'b10 : 2'b00;
      dc = ($urandom % 2) ? 2'b10 : 2'b00;
      start(md, sc, dc, $urandom & 32'hffff_fffc, $urandom & 32'hffff_fffc,
            16'(4 * (1 + $urandom % 10)), 1);
      run_idle();
    end

    // R8 wrap on source, disable inside write phase (R9)
    start(2'b00, 2'b11, 2'b00, 32'h1000, 32'h8000, 16'd8, 1);
    while (nwr < 0 || 1) begin tick(); if (wr_valid_o && !wr_ready_i && cnt_chk == 0 && nwr > 0 && (nwr % 5 == 0)) break; end
    w0 = nwr;
    en_i = 0; rd_ready_i = 0; wr_ready_i = 0;
    @(negedge clk_i);
    chk(!busy_o && !wr_valid_o, "R9 pending write withdrawn", {busy_o, wr_valid_o}, 0);
    repeat (4) tick();
    chk(nwr == w0, "R9 no write after disable", nwr, w0);
    en_i = 1;

    // R8 wrap on both sides, several passes
    start(2'b00, 2'b11, 2'b11, 32'h2000, 32'h3000, 16'd12, 1);
    while (nwr < w0 + 10) tick();
    chk(busy_o == 1, "R8 still running after passes", busy_o, 1);
    // R9: disable while read stalled
    hold_rd = 1;
    while (!rd_valid_o) tick();
    tick();
    en_i = 0;
    n0 = nrd; w0 = nwr; cnt_chk = 0;
    repeat (3) tick();
    chk(rd_valid_o == 1, "R9 read held until accepted", rd_valid_o, 1);
    hold_rd = 0;
    run_idle();
    chk(nrd == n0 + 1, "R9 read completed", nrd, n0 + 1);
    chk(nwr == w0, "R9 captured word dropped", nwr, w0);
    en_i = 1;

    // R10 error on read
    start(2'b00, 2'b00, 2'b00, 32'h400, 32'h500, 16'd16, 1);
    inject_rd_err = 1;
    run_idle();
    chk(err_o == 1 && !rd_valid_o && !wr_valid_o, "R10 halted on error", err_o, 1);
    start(2'b00, 2'b00, 2'b00, 32'h400, 32'h500, 16'd16, 0);
    chk(err_o == 1, "R10 error sticky", err_o, 1);

    // R11 soft reset length and clearing
    @(negedge clk_i); srst_i = 1;
    @(negedge clk_i); srst_i = 0;
    chk(!err_o && cur_cnt_o == 0 && cur_src_o == 0 && cur_dst_o == 0, "R11 state cleared", err_o, 0);
    len = 0;
    for (int k = 0; k < 8; k++) begin
      if (srst_busy_o) len++;
      @(negedge clk_i);
    end
    chk(len == 3, "R11 soft reset length", len, 3);
    @(negedge clk_i); srst_i = 1;
    @(negedge clk_i); srst_i = 0;
    start(2'b00, 2'b00, 2'b00, 32'h40, 32'h80, 16'd4, 0);
    chk(srst_busy_o == 1, "R11 trigger ignored during soft reset", srst_busy_o, 1);
    repeat (4) @(negedge clk_i);
    chk(srst_busy_o == 0, "R11 soft reset ends", srst_busy_o, 0);
    start(2'b01, 2'b00, 2'b00, 32'h40, 32'h80, 16'd12, 1);
    run_idle();
    chk(cur_src_o == 32'h40 && cur_dst_o == 32'h8c, "R6 periph source fixed, dest advanced", cur_src_o, 32'h40);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule